// File: doc/BRIEF.md
# Edge-Event GPIO Port

A 32-pin general-purpose I/O port on a plain register bus with a word address, write data, a write strobe and combinational read data. Software drives pins through an output-level register and an output-enable register. Neither is ever written directly: every change goes through write-one-to-set, write-one-to-clear or write-one-to-toggle aliases, so one pin can be changed without a read-modify-write that could race with another owner. A pin's output level is kept while its enable is off, and it comes back on the pad when the enable returns.

Every input passes through a synchronizer and then an edge detector. Each pin has its own 2-bit polarity field: off, rising, falling or both. Detected edges set sticky raw status bits. Software clears a bit by writing a 1 to it. A mask selects which raw bits drive the single interrupt line.

The power-enable and soft-reset registers act only when a write carries an unlock key in its top byte. While power is off, every other write is ignored and no edge is recorded.

Top module: `gpio_edge_port`

## Requirements
- R1: After rst_ni, every readable register, pin_o, pin_oe_o and irq_o is 0.
- R2: Writing to address 1 ORs the write data into the output level, address 2 clears the bits written as 1, and address 3 inverts them. Zero bits leave their pins unchanged. The level reads back at address 0.
- R3: Address 5 sets and address 6 clears output-enable bits under the same write-one rule, and the enable reads back at address 4. pin_o equals level AND enable, pin_oe_o equals the enable, and the level is kept while the enable is off.
- R4: Address 7 reads the pins through a two-flop synchronizer: a pin change is visible after the second rising clock edge and not after the first.
- R5: Address 8 holds the polarity of pins 0 to 15 and address 9 holds pins 16 to 31. Pin p uses bits [2p+1:2p] at address 8 or bits [2(p-16)+1:2(p-16)] at address 9. The encoding is 00 off, 01 rising, 10 falling, 11 both. Both registers read back as written.
- R6: A synchronized edge that matches a pin's polarity sets bit p of the raw status register (address 11). With polarity 00 no event is recorded. Raw bits stay set until they are cleared.
- R7: Writing to address 13 clears the raw bits written as 1, and zero bits have no effect. An event and a clear that hit the same bit in the same cycle leave the bit set.
- R8: The mask register (address 10) is read/write, with 1 meaning enabled. Address 12 reads raw AND mask, and irq_o is the OR of those bits.
- R9: A write to address 14 with 8'hA5 in bits [31:24] sets the power enable to bit 0, which reads back in bit 0. A write with any other key is ignored. While power is 0, writes to addresses 1 to 13 are ignored and no event is recorded.
- R10: A write to address 15 with key 8'hA5 and bit 0 set returns every register to 0, power included. With a wrong key it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pin_i | input | 32 | Pad input levels (asynchronous) |
| pin_o | output | 32 | Driven output levels |
| pin_oe_o | output | 32 | Per-pin output enable |
| irq_o | output | 1 | OR of masked raw status |

## Verification
The bench collides an edge event with a clear of the same bit in the same cycle. A design where the clear wins would lose that event and read the bit back as 0. It places a rising-only field for pin 20 in the upper polarity register and toggles pin 4 as well, so a design that misplaces fields in the split registers would flag the wrong pin. It checks the input register one edge and two edges after a pin change, which exposes a missing or extra synchronizer stage. It also issues wrong-key power and reset writes and alias writes while power is off: a design that lets them through would show a changed level or power bit on readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NPINS   = 32;
  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 4;
  localparam int unsigned HALF    = NPINS / 2;
  localparam int unsigned POLW    = 2 * NPINS;
  localparam int unsigned KEY_W   = 8;
  localparam int unsigned KEY_LSB = DW - KEY_W;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [AW-1:0] A_LVL     = 4'd0;
  localparam logic [AW-1:0] A_LVL_SET = 4'd1;
  localparam logic [AW-1:0] A_LVL_CLR = 4'd2;
  localparam logic [AW-1:0] A_LVL_TGL = 4'd3;
  localparam logic [AW-1:0] A_EN      = 4'd4;
  localparam logic [AW-1:0] A_EN_SET  = 4'd5;
  localparam logic [AW-1:0] A_EN_CLR  = 4'd6;
  localparam logic [AW-1:0] A_IN      = 4'd7;
  localparam logic [AW-1:0] A_POL_LO  = 4'd8;
  localparam logic [AW-1:0] A_POL_HI  = 4'd9;
  localparam logic [AW-1:0] A_MASK    = 4'd10;
  localparam logic [AW-1:0] A_RAW     = 4'd11;
  localparam logic [AW-1:0] A_MSK_ST  = 4'd12;
  localparam logic [AW-1:0] A_EVCLR   = 4'd13;
  localparam logic [AW-1:0] A_PWR     = 4'd14;
  localparam logic [AW-1:0] A_SRST    = 4'd15;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_port_pkg::*;
#(
  parameter int unsigned N = NPINS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   lvl_i,
  input  logic [2*N-1:0] pol_i,
  output logic [N-1:0]   ev_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < N; p++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];
    always_comb begin
      unique case (edge_sel_e'(pol_i[2*p +: 2]))
        EDGE_RISE: ev_o[p] = rise;
        EDGE_FALL: ev_o[p] = fall;
        EDGE_BOTH: ev_o[p] = rise | fall;
        default:   ev_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPINS-1:0] din_i,
  input  logic [NPINS-1:0] ev_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] en_o,
  output logic [POLW-1:0]  pol_o,
  output logic [NPINS-1:0] raw_o,
  output logic [NPINS-1:0] mask_o,
  output logic             pwr_o
);
  logic [NPINS-1:0] lvl_q, en_q, mask_q, raw_q, raw_n;
  logic [2*HALF-1:0] pol_lo_q, pol_hi_q;
  logic pwr_q;
  logic key_ok, soft_rst, pwr_wr, live_we;
  logic [NPINS-1:0] clr_bits, ev_bits;

  assign key_ok   = (wdata_i[KEY_LSB +: KEY_W] == UNLOCK_KEY);
  assign soft_rst = we_i && (addr_i == A_SRST) && key_ok && wdata_i[0];
  assign pwr_wr   = we_i && (addr_i == A_PWR) && key_ok;
  assign live_we  = we_i && pwr_q;

  // event has priority over a clear of the same bit
  assign clr_bits = (live_we && addr_i == A_EVCLR) ? wdata_i[NPINS-1:0] : '0;
  assign ev_bits  = pwr_q ? ev_i : '0;
  assign raw_n    = (raw_q & ~clr_bits) | ev_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= '0;
      en_q     <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      pol_lo_q <= '0;
      pol_hi_q <= '0;
      pwr_q    <= 1'b0;
    end else if (soft_rst) begin
      lvl_q    <= '0;
      en_q     <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      pol_lo_q <= '0;
      pol_hi_q <= '0;
      pwr_q    <= 1'b0;
    end else begin
      if (pwr_wr) pwr_q <= wdata_i[0];
      if (live_we) begin
        unique case (addr_i)
          A_LVL_SET: lvl_q    <= lvl_q | wdata_i[NPINS-1:0];
          A_LVL_CLR: lvl_q    <= lvl_q & ~wdata_i[NPINS-1:0];
          A_LVL_TGL: lvl_q    <= lvl_q ^ wdata_i[NPINS-1:0];
          A_EN_SET:  en_q     <= en_q | wdata_i[NPINS-1:0];
          A_EN_CLR:  en_q     <= en_q & ~wdata_i[NPINS-1:0];
          A_POL_LO:  pol_lo_q <= wdata_i[2*HALF-1:0];
          A_POL_HI:  pol_hi_q <= wdata_i[2*HALF-1:0];
          A_MASK:    mask_q   <= wdata_i[NPINS-1:0];
          default: ;
        endcase
      end
      raw_q <= raw_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LVL:    rdata_o[NPINS-1:0]  = lvl_q;
      A_EN:     rdata_o[NPINS-1:0]  = en_q;
      A_IN:     rdata_o[NPINS-1:0]  = din_i;
      A_POL_LO: rdata_o[2*HALF-1:0] = pol_lo_q;
      A_POL_HI: rdata_o[2*HALF-1:0] = pol_hi_q;
      A_MASK:   rdata_o[NPINS-1:0]  = mask_q;
      A_RAW:    rdata_o[NPINS-1:0]  = raw_q;
      A_MSK_ST: rdata_o[NPINS-1:0]  = raw_q & mask_q;
      A_PWR:    rdata_o[0]          = pwr_q;
      default:  rdata_o = '0;
    endcase
  end

  assign lvl_o  = lvl_q;
  assign en_o   = en_q;
  assign pol_o  = {pol_hi_q, pol_lo_q};
  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign pwr_o  = pwr_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_we_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  logic [NPINS-1:0] din_s, ev, lvl_w, en_w, raw_w, mask_w;
  logic [POLW-1:0]  pol_w;
  logic             pwr_w;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(din_s)
  );

  gpio_edge_det #(.N(NPINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(din_s), .pol_i(pol_w), .ev_o(ev)
  );

  gpio_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .rdata_o(bus_rdata_o),
    .din_i(din_s), .ev_i(ev),
    .lvl_o(lvl_w), .en_o(en_w), .pol_o(pol_w),
    .raw_o(raw_w), .mask_o(mask_w), .pwr_o(pwr_w)
  );

  assign pin_o    = lvl_w & en_w;
  assign pin_oe_o = en_w;
  assign irq_o    = |(raw_w & mask_w);
endmodule

// File: rtl/gpio_port_sva.sv
module gpio_port_sva
  import gpio_port_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             we,
  input logic [NPINS-1:0] lvl,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] mask,
  input logic             pwr,
  input logic             irq
);
  logic key_ok;
  assign key_ok = (wdata[KEY_LSB +: KEY_W] == UNLOCK_KEY);

  p_lvl_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && pwr && addr == A_LVL_SET) |=> ((lvl & $past(wdata)) == $past(wdata)));

  p_lvl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && pwr && addr == A_LVL_TGL) |=> ((lvl & ~$past(wdata)) == ($past(lvl) & ~$past(wdata))));

  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && pwr && addr == A_EN_CLR) |=> ((en & $past(wdata)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we |=> ($stable(lvl) && $stable(en)));

  p_raw_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we |=> ((raw & $past(raw)) == $past(raw)));

  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw == '0 || mask == '0) |-> !irq);

  p_bad_key_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == A_PWR && !key_ok) |=> (pwr == $past(pwr)));

  p_off_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr && !we) |=> $stable(raw));

  p_soft_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == A_SRST && key_ok && wdata[0]) |=>
      (lvl == '0 && en == '0 && raw == '0 && mask == '0 && !pwr));
endmodule

bind gpio_edge_port gpio_port_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .addr(bus_addr_i), .wdata(bus_wdata_i), .we(bus_we_i),
  .lvl(lvl_w), .en(en_w), .raw(raw_w), .mask(mask_w), .pwr(pwr_w), .irq(irq_o)
);

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
  import gpio_port_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata, pins = '0, pout, poe;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_lvl = '0, m_en = '0, m_raw = '0, m_mask = '0;
  logic [31:0] m_plo = '0, m_phi = '0;

  always #4 clk = ~clk;

  gpio_edge_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [1:0] pol_of(input int p);
    if (p < 16) return m_plo[2*p +: 2];
    return m_phi[2*(p-16) +: 2];
  endfunction

  function automatic logic [31:0] edges(input logic [31:0] o, input logic [31:0] n);
    logic [31:0] e = '0;
    for (int p = 0; p < 32; p++) begin
      logic [1:0] s = pol_of(p);
      if (s[0] && !o[p] && n[p]) e[p] = 1'b1;
      if (s[1] && o[p] && !n[p]) e[p] = 1'b1;
    end
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, old;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 pin_o", pout, 0);
    chk("R1 pin_oe_o", poe, 0);
    chk("R1 irq_o", {31'b0, irq}, 0);

    // R9 power gating and key
    wr(A_LVL_SET, 32'hFFFF_FFFF);
    rd(A_LVL, v); chk("R9 write while off", v, 0);
    wr(A_PWR, 32'h5A00_0001);
    rd(A_PWR, v); chk("R9 bad key", v, 0);
    wr(A_PWR, 32'hA500_0001);
    rd(A_PWR, v); chk("R9 good key", v, 1);

    // R2 R3 random alias traffic
    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 5;
      logic [31:0] d = $urandom;
      case (op)
        0: begin wr(A_LVL_SET, d); m_lvl = m_lvl | d; end
        1: begin wr(A_LVL_CLR, d); m_lvl = m_lvl & ~d; end
        2: begin wr(A_LVL_TGL, d); m_lvl = m_lvl ^ d; end
        3: begin wr(A_EN_SET, d);  m_en = m_en | d; end
        default: begin wr(A_EN_CLR, d); m_en = m_en & ~d; end
      endcase
      rd(A_LVL, v); chk("R2 level", v, m_lvl);
      rd(A_EN, v);  chk("R3 enable", v, m_en);
      chk("R3 pin_o", pout, m_lvl & m_en);
      chk("R3 pin_oe_o", poe, m_en);
    end
    wr(A_LVL_SET, 32'h0);
    rd(A_LVL, v); chk("R2 zero set", v, m_lvl);

    // R3 level kept while disabled
    wr(A_EN_CLR, 32'hFFFF_FFFF); m_en = 0;
    wr(A_LVL_CLR, 32'hFFFF_FFFF);
    wr(A_LVL_SET, 32'hC3A5_0F18); m_lvl = 32'hC3A5_0F18;
    chk("R3 off pin_o", pout, 0);
    wr(A_EN_SET, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
    chk("R3 restored pin_o", pout, m_lvl);

    // R4 synchronizer latency
    for (int i = 0; i < 8; i++) begin
      rd(A_IN, old);
      @(negedge clk); pins = $urandom;
      @(negedge clk); rd(A_IN, v); chk("R4 one edge", v, old);
      @(negedge clk); rd(A_IN, v); chk("R4 two edges", v, pins);
    end
    pins = '0;
    repeat (4) @(negedge clk);
    wr(A_EVCLR, 32'hFFFF_FFFF);

    // R5 split field placement: pin 20 rising only
    m_plo = 0; m_phi = 32'h0000_0100;
    wr(A_POL_LO, m_plo); wr(A_POL_HI, m_phi);
    @(negedge clk); pins = 32'h0010_0010;
    repeat (4) @(negedge clk);
    rd(A_RAW, v); chk("R5 pin20 field", v, 32'h0010_0000);
    rd(A_POL_HI, v); chk("R5 readback", v, m_phi);
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);
    rd(A_RAW, v); chk("R6 rising only ignores fall", v, 32'h0010_0000);
    wr(A_EVCLR, 32'hFFFF_FFFF); m_raw = 0;

    // R6 R8 random polarity and pin traffic
    m_plo = $urandom; m_phi = $urandom; m_mask = $urandom;
    wr(A_POL_LO, m_plo); wr(A_POL_HI, m_phi); wr(A_MASK, m_mask);
    rd(A_POL_LO, v); chk("R5 readback lo", v, m_plo);
    rd(A_MASK, v); chk("R8 mask readback", v, m_mask);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] n = $urandom;
      m_raw = m_raw | edges(pins, n);
      @(negedge clk); pins = n;
      repeat (4) @(negedge clk);
      rd(A_RAW, v); chk("R6 raw", v, m_raw);
      rd(A_MSK_ST, v); chk("R8 masked", v, m_raw & m_mask);
      chk("R8 irq_o", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
      if (i % 15 == 14) begin
        logic [31:0] c = $urandom;
        wr(A_EVCLR, c); m_raw = m_raw & ~c;
        rd(A_RAW, v); chk("R7 clear", v, m_raw);
      end
    end
    wr(A_EVCLR, 32'h0);
    rd(A_RAW, v); chk("R7 zero clear", v, m_raw);

    // R6 disabled polarity records nothing
    wr(A_POL_LO, 0); wr(A_POL_HI, 0); m_plo = 0; m_phi = 0;
    wr(A_EVCLR, 32'hFFFF_FFFF);
    @(negedge clk); pins = ~pins;
    repeat (4) @(negedge clk);
    rd(A_RAW, v); chk("R6 polarity off", v, 0);
    chk("R8 irq low", {31'b0, irq}, 0);

    // R7 event wins over same-cycle clear, pin 3 both edges
    pins[3] = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_POL_LO, 32'h0000_00C0);
    wr(A_EVCLR, 32'hFFFF_FFFF);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = A_EVCLR; wdata = 32'h0000_0008; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    rd(A_RAW, v); chk("R7 event wins", v, 32'h0000_0008);

    // R9 writes ignored when powered off
    wr(A_PWR, 32'hA500_0000);
    rd(A_LVL, old);
    wr(A_LVL_TGL, 32'hFFFF_FFFF);
    rd(A_LVL, v); chk("R9 off toggle ignored", v, old);
    wr(A_EVCLR, 32'hFFFF_FFFF);
    rd(A_RAW, v); chk("R9 off clear ignored", v, 32'h0000_0008);
    wr(A_PWR, 32'hA500_0001);

    // R10 keyed soft reset
    wr(A_SRST, 32'h1200_0001);
    rd(A_LVL, v); chk("R10 bad key", v, old);
    rd(A_PWR, v); chk("R10 bad key pwr", v, 1);
    wr(A_SRST, 32'hA500_0001);
    for (int a = 0; a < 16; a++) begin
      if (a != 7) begin
        rd(a[3:0], v);
        chk("R10 cleared", v, 0);
      end
    end
    chk("R10 pin_oe_o", poe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule